// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block sits behind a UART's serial deserializer. It stores received characters in a 16-entry FIFO and produces the receive-side interrupts. Each finished character arrives as a one-cycle valid pulse with its byte. A baud tick pulses once per bit time. A high-speed control bit doubles the idle window. The host pops characters through a simple read strobe, and the oldest character is always visible on the read data bus.

Two interrupts are central. The fill-level interrupt tells the host that the FIFO holds at least a programmable number of characters. The receive-timeout interrupt covers the leftovers: characters below the trigger level that would otherwise never be reported. It fires when the FIFO holds data and nothing has arrived or been read for 32 bit times, or 64 bit times in high-speed mode. It is an informational event, not an error, and it drops by itself once the FIFO is drained.

Framing, parity and break errors are detected upstream. They enter as pulses and only become sticky status bits. A small register write port sets the interrupt mask and the trigger level, and clears status with write-1-to-clear semantics. Raw and masked status are presented as output buses.

Top module: `uart_rx_irq_ctrl`

## Requirements
- R1: The FIFO is 16 entries deep and first-in first-out. `rdData` shows the oldest entry, or 0 when the FIFO is empty. `rdEn` removes that entry. A read of an empty FIFO changes nothing.
- R2: The trigger level is a 3-bit field written with `regSel`=2 and taken from `regWdata[2:0]`. The codes map as follows: 0 to 2 entries, 1 to 4, 2 to 8, 3 to 12, and 4 through 7 to 14. Reset selects code 2. Raw status bit 4 is 1 whenever the fill level is at least the selected trigger level.
- R3: An idle counter advances once per baud tick while the FIFO holds data. It returns to zero on any cycle with `rxValid`, on any cycle with `rdEn`, and while the FIFO is empty.
- R4: Raw status bit 6 (timeout) becomes 1 in the cycle after the 32nd counted tick when `highSpeed`=0, or after the 64th when `highSpeed`=1. It fires once per idle period.
- R5: The timeout bit returns to 0 on the same clock edge at which the FIFO becomes empty, and it is never 1 while the FIFO is empty.
- R6: A write with `regSel`=1 clears each of status bits 6 to 10 whose `regWdata` bit is 1. A 0 bit leaves the status unchanged. A new event in the same cycle wins over the clear. Bit 4 is not affected by this write.
- R7: A character that arrives while the FIFO is full, and no entry is popped in that cycle, is dropped. It sets the sticky overrun bit 10, which also drives `overrunFlag`.
- R8: The framing, parity and break input pulses set the sticky status bits 7, 8 and 9 respectively.
- R9: A write with `regSel`=0 loads the mask from `regWdata`. Masked status equals raw status AND mask. `levelIrq` is masked bit 4, `timeoutIrq` is masked bit 6, and `irqOut` is the OR of all masked bits.
- R10: After reset the FIFO is empty, all status bits and the mask are 0, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle pulse: a received character is on `rxData` |
| rxData | input | 8 | Received character |
| frameErrIn | input | 1 | Framing error pulse from the deserializer |
| parityErrIn | input | 1 | Parity error pulse from the deserializer |
| breakErrIn | input | 1 | Break condition pulse from the deserializer |
| baudTick | input | 1 | One pulse per bit time |
| highSpeed | input | 1 | 1 selects the 64-bit-time idle window, 0 selects 32 |
| rdEn | input | 1 | Host pop of the oldest character |
| rdData | output | 8 | Oldest character, 0 when empty |
| fifoLevel | output | 5 | Number of stored characters |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | 0 mask, 1 clear, 2 trigger level, 3 unused |
| regWdata | input | 11 | Register write data |
| rawStatus | output | 11 | Raw status bits |
| maskedStatus | output | 11 | Raw status AND mask |
| levelIrq | output | 1 | Masked fill-level interrupt |
| timeoutIrq | output | 1 | Masked receive-timeout interrupt |
| overrunFlag | output | 1 | Sticky overrun status |
| irqOut | output | 1 | OR of all masked status bits |

## Verification
The bench targets the edges of the idle window: no timeout after 31 ticks and a timeout after the 32nd. It repeats this with 63 and 64 ticks in high-speed mode. A counter that is off by one, or that ignores the mode bit, misses these marks by a cycle. It also checks that the timeout does not return after a write-1 clear while data remains. A design without the once-per-idle-period rule would raise it again. Further checks cover a zero write to the clear register, a FIFO drained on the same edge as a timeout, a push into a full FIFO with and without a pop in that cycle, and a read of an empty FIFO. Getting any of these wrong would leave a stale interrupt, lose or duplicate a character, or corrupt the level. Long random runs compare every output each cycle against a model built from the requirements.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;
  localparam int STAT_W  = 11;
  localparam int BIT_LVL = 4;
  localparam int BIT_RTO = 6;
  localparam int BIT_FE  = 7;
  localparam int BIT_PE  = 8;
  localparam int BIT_BE  = 9;
  localparam int BIT_OE  = 10;

  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_CLR  = 2'd1;
  localparam logic [1:0] SEL_TRIG = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic tickClr;
    logic tickInc;
  } dpStrobe_t;
endpackage

// File: rtl/rx_fifo_dp.sv
module rx_fifo_dp
  import uart_rx_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TICK_W = 7,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level,
  output logic [TICK_W-1:0] tickCnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (stb.push) wrPtr <= ptrInc(wrPtr);
      if (stb.pop)  rdPtr <= ptrInc(rdPtr);
      level <= level + LVL_W'(stb.push) - LVL_W'(stb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            tickCnt <= '0;
    else if (stb.tickClr) tickCnt <= '0;
    else if (stb.tickInc) tickCnt <= tickCnt + 1'b1;
  end

  assign headData = (level != '0) ? mem[rdPtr] : '0;
endmodule

// File: rtl/rx_irq_ctl.sv
module rx_irq_ctl
  import uart_rx_irq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int TICK_W      = 7,
  parameter int LVL_W       = $clog2(DEPTH + 1),
  parameter int RTO_BITS    = 32,
  parameter int RTO_BITS_HS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rdEn,
  input  logic              baudTick,
  input  logic              highSpeed,
  input  logic              frameErrIn,
  input  logic              parityErrIn,
  input  logic              breakErrIn,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [STAT_W-1:0] regWdata,
  input  logic [LVL_W-1:0]  level,
  input  logic [TICK_W-1:0] tickCnt,
  output dpStrobe_t         stb,
  output logic [STAT_W-1:0] rawStatus,
  output logic [STAT_W-1:0] maskedStatus
);
  logic [STAT_W-1:0] maskReg;
  logic [2:0]        trigSel;
  logic              rtoFlag, feFlag, peFlag, beFlag, oeFlag;
  logic              isEmpty, isFull, clrWr;
  logic [TICK_W-1:0] limit, tickNext;
  logic [LVL_W-1:0]  levelAfter, trigLevel;
  logic              rtoHit, drainsEmpty, dropChar;

  assign isEmpty = (level == '0);
  assign isFull  = (level == LVL_W'(DEPTH));
  assign clrWr   = regWe && (regSel == SEL_CLR);

  always_comb begin
    stb.pop     = rdEn && !isEmpty;
    stb.push    = rxValid && (!isFull || stb.pop);
    stb.tickClr = rxValid || rdEn || isEmpty;
    limit       = highSpeed ? TICK_W'(RTO_BITS_HS) : TICK_W'(RTO_BITS);
    tickNext    = tickCnt + 1'b1;
    stb.tickInc = baudTick && !stb.tickClr && (tickCnt < limit);
  end

  assign rtoHit      = stb.tickInc && (tickNext == limit);
  assign levelAfter  = level + LVL_W'(stb.push) - LVL_W'(stb.pop);
  assign drainsEmpty = (levelAfter == '0);
  assign dropChar    = rxValid && !stb.push;

  always_comb begin
    case (trigSel)
      3'd0:    trigLevel = LVL_W'(DEPTH / 8);
      3'd1:    trigLevel = LVL_W'(DEPTH / 4);
      3'd2:    trigLevel = LVL_W'(DEPTH / 2);
      3'd3:    trigLevel = LVL_W'((DEPTH * 3) / 4);
      default: trigLevel = LVL_W'(DEPTH - 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      trigSel <= 3'd2;
    end else if (regWe) begin
      if (regSel == SEL_MASK) maskReg <= regWdata;
      if (regSel == SEL_TRIG) trigSel <= regWdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtoFlag <= 1'b0;
      feFlag  <= 1'b0;
      peFlag  <= 1'b0;
      beFlag  <= 1'b0;
      oeFlag  <= 1'b0;
    end else begin
      if (drainsEmpty) rtoFlag <= 1'b0;
      else if (rtoHit) rtoFlag <= 1'b1;
      else if (clrWr && regWdata[BIT_RTO]) rtoFlag <= 1'b0;
      feFlag <= frameErrIn  || (feFlag && !(clrWr && regWdata[BIT_FE]));
      peFlag <= parityErrIn || (peFlag && !(clrWr && regWdata[BIT_PE]));
      beFlag <= breakErrIn  || (beFlag && !(clrWr && regWdata[BIT_BE]));
      oeFlag <= dropChar    || (oeFlag && !(clrWr && regWdata[BIT_OE]));
    end
  end

  always_comb begin
    rawStatus          = '0;
    rawStatus[BIT_LVL] = (level >= trigLevel);
    rawStatus[BIT_RTO] = rtoFlag;
    rawStatus[BIT_FE]  = feFlag;
    rawStatus[BIT_PE]  = peFlag;
    rawStatus[BIT_BE]  = beFlag;
    rawStatus[BIT_OE]  = oeFlag;
    maskedStatus       = rawStatus & maskReg;
  end
endmodule

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl
  import uart_rx_irq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 8,
  parameter int RTO_BITS    = 32,
  parameter int RTO_BITS_HS = 64,
  parameter int LVL_W       = $clog2(DEPTH + 1),
  parameter int TICK_W      = $clog2(RTO_BITS_HS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              frameErrIn,
  input  logic              parityErrIn,
  input  logic              breakErrIn,
  input  logic              baudTick,
  input  logic              highSpeed,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  fifoLevel,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [STAT_W-1:0] regWdata,
  output logic [STAT_W-1:0] rawStatus,
  output logic [STAT_W-1:0] maskedStatus,
  output logic              levelIrq,
  output logic              timeoutIrq,
  output logic              overrunFlag,
  output logic              irqOut
);
  dpStrobe_t         stb;
  logic [TICK_W-1:0] tickCnt;

  rx_fifo_dp #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .TICK_W(TICK_W), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(rxData),
    .headData(rdData), .level(fifoLevel), .tickCnt(tickCnt)
  );

  rx_irq_ctl #(
    .DEPTH(DEPTH), .TICK_W(TICK_W), .LVL_W(LVL_W),
    .RTO_BITS(RTO_BITS), .RTO_BITS_HS(RTO_BITS_HS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdEn(rdEn),
    .baudTick(baudTick), .highSpeed(highSpeed),
    .frameErrIn(frameErrIn), .parityErrIn(parityErrIn), .breakErrIn(breakErrIn),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .level(fifoLevel), .tickCnt(tickCnt), .stb(stb),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus)
  );

  assign levelIrq    = maskedStatus[BIT_LVL];
  assign timeoutIrq  = maskedStatus[BIT_RTO];
  assign overrunFlag = rawStatus[BIT_OE];
  assign irqOut      = |maskedStatus;
endmodule

// File: rtl/uart_rx_irq_chk.sv
module uart_rx_irq_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rdEn,
  input logic             baudTick,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             rtoRaw,
  input logic             oeRaw,
  input logic             oeClr,
  input logic             timeoutIrq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH)); // R1

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rxValid && fifoLevel == '0) |=> fifoLevel == '0); // R1

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rxValid && fifoLevel != '0) |=> fifoLevel == $past(fifoLevel) - 1'b1); // R1

  AST_RTO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rtoRaw |-> fifoLevel != '0); // R5

  AST_RTO_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtoRaw) |-> $past(baudTick)); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (oeRaw && !oeClr) |=> oeRaw); // R7

  AST_RTO_IRQ_RAW: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> rtoRaw); // R9
endmodule

bind uart_rx_irq_ctrl uart_rx_irq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdEn(rdEn), .baudTick(baudTick),
  .fifoLevel(fifoLevel), .rtoRaw(rawStatus[6]), .oeRaw(rawStatus[10]),
  .oeClr(regWe && regSel == 2'd1 && regWdata[10]), .timeoutIrq(timeoutIrq)
);

// File: tb/tb_uart_rx_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_rx_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 0, frameErrIn = 0, parityErrIn = 0, breakErrIn = 0;
  logic [7:0]  rxData = '0;
  logic        baudTick = 0, highSpeed = 0, rdEn = 0, regWe = 0;
  logic [1:0]  regSel = '0;
  logic [10:0] regWdata = '0;
  logic [7:0]  rdData;
  logic [4:0]  fifoLevel;
  logic [10:0] rawStatus, maskedStatus;
  logic        levelIrq, timeoutIrq, overrunFlag, irqOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_rx_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .frameErrIn(frameErrIn), .parityErrIn(parityErrIn), .breakErrIn(breakErrIn),
    .baudTick(baudTick), .highSpeed(highSpeed), .rdEn(rdEn), .rdData(rdData),
    .fifoLevel(fifoLevel), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .levelIrq(levelIrq),
    .timeoutIrq(timeoutIrq), .overrunFlag(overrunFlag), .irqOut(irqOut)
  );

  // reference model state
  logic [7:0]  q[$];
  int          mTick = 0;
  logic        mRto = 0, mFe = 0, mPe = 0, mBe = 0, mOe = 0;
  logic [10:0] mMask = '0;
  logic [2:0]  mTrig = 3'd2;

  function automatic int trigLvl(input logic [2:0] s);
    case (s)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 14;
    endcase
  endfunction

  function automatic logic [10:0] expRaw();
    logic [10:0] r = '0;
    r[4] = (q.size() >= trigLvl(mTrig));
    r[6] = mRto; r[7] = mFe; r[8] = mPe; r[9] = mBe; r[10] = mOe;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int sz = q.size();
    int lim = highSpeed ? 64 : 32;
    logic pop = rdEn && sz > 0;
    logic push = rxValid && (sz < 16 || pop);
    logic clr = rxValid || rdEn || sz == 0;
    logic inc = baudTick && !clr && (mTick < lim);
    logic hit = inc && (mTick + 1 == lim);
    int nsz = sz - int'(pop) + int'(push);
    logic [10:0] w = (regWe && regSel == 2'd1) ? regWdata : 11'd0;
    if (nsz == 0) mRto = 0;
    else if (hit) mRto = 1;
    else if (w[6]) mRto = 0;
    mFe = frameErrIn  | (mFe & !w[7]);
    mPe = parityErrIn | (mPe & !w[8]);
    mBe = breakErrIn  | (mBe & !w[9]);
    mOe = (rxValid && !push) | (mOe & !w[10]);
    mTick = clr ? 0 : (inc ? mTick + 1 : mTick);
    if (regWe && regSel == 2'd0) mMask = regWdata;
    if (regWe && regSel == 2'd2) mTrig = regWdata[2:0];
    if (pop)  void'(q.pop_front());
    if (push) q.push_back(rxData);
  endtask

  task automatic compareAll(input string tag);
    logic [10:0] r = expRaw();
    logic [10:0] m = r & mMask;
    chk({tag, " rdData"}, 32'(rdData), 32'((q.size() > 0) ? q[0] : 8'd0));
    chk({tag, " fifoLevel"}, 32'(fifoLevel), 32'(q.size()));
    chk({tag, " rawStatus"}, 32'(rawStatus), 32'(r));
    chk({tag, " maskedStatus"}, 32'(maskedStatus), 32'(m));
    chk({tag, " levelIrq"}, 32'(levelIrq), 32'(m[4]));
    chk({tag, " timeoutIrq"}, 32'(timeoutIrq), 32'(m[6]));
    chk({tag, " overrunFlag"}, 32'(overrunFlag), 32'(r[10]));
    chk({tag, " irqOut"}, 32'(irqOut), 32'(|m));
  endtask

  task automatic setIdle();
    rxValid = 0; frameErrIn = 0; parityErrIn = 0; breakErrIn = 0;
    baudTick = 0; rdEn = 0; regWe = 0; regSel = '0; regWdata = '0;
  endtask

  task automatic cyc(input string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic pushB(input logic [7:0] b, input string tag);
    setIdle(); rxValid = 1; rxData = b; cyc(tag);
  endtask

  task automatic popB(input string tag);
    setIdle(); rdEn = 1; cyc(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      setIdle(); baudTick = 1; cyc(tag);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [10:0] d, input string tag);
    setIdle(); regWe = 1; regSel = s; regWdata = d; cyc(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    setIdle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 reset state
    chk("R10 fifoLevel", 32'(fifoLevel), 0);
    chk("R10 rawStatus", 32'(rawStatus), 0);
    chk("R10 maskedStatus", 32'(maskedStatus), 0);
    chk("R10 irqOut", 32'(irqOut), 0);
    chk("R10 rdData", 32'(rdData), 0);

    wrReg(2'd0, 11'h7D0, "R9 mask");
    chk("R9 masked zero", 32'(maskedStatus), 0);
    wrReg(2'd2, 11'd1, "R2 trig4");

    // burst of six with trigger 4
    for (int i = 0; i < 6; i++) begin
      pushB(8'hA0 + 8'(i), "R1 burst");
      if (i == 2) chk("R2 below trigger", 32'(levelIrq), 0);
      if (i == 3) chk("R2 at trigger", 32'(levelIrq), 1);
    end
    chk("R1 level six", 32'(fifoLevel), 6);
    for (int i = 0; i < 4; i++) begin
      chk("R1 order", 32'(rdData), 32'(8'hA0 + 8'(i)));
      popB("R1 pop");
    end
    chk("R2 level dropped", 32'(levelIrq), 0);
    ticks(31, "R4 wait");
    chk("R4 no timeout at 31", 32'(timeoutIrq), 0);
    ticks(1, "R4 hit");
    chk("R4 timeout at 32", 32'(timeoutIrq), 1);
    chk("R9 irqOut", 32'(irqOut), 1);
    ticks(40, "R4 hold");
    wrReg(2'd1, 11'h000, "R6 zero");
    chk("R6 zero write no effect", 32'(rawStatus[6]), 1);
    wrReg(2'd1, 11'h040, "R6 clear");
    chk("R6 cleared", 32'(rawStatus[6]), 0);
    ticks(40, "R4 once");
    chk("R4 once per idle", 32'(rawStatus[6]), 0);
    pushB(8'h55, "R3 restart");
    ticks(32, "R3 count");
    chk("R3 refire after char", 32'(rawStatus[6]), 1);
    popB("R5 drain"); popB("R5 drain"); popB("R5 drain");
    chk("R5 empty clears timeout", 32'(rawStatus[6]), 0);
    chk("R5 empty", 32'(fifoLevel), 0);

    // high-speed window
    setIdle(); highSpeed = 1; cyc("R4 hs");
    pushB(8'h11, "R4 hs push");
    ticks(63, "R4 hs wait");
    chk("R4 hs no timeout at 63", 32'(rawStatus[6]), 0);
    ticks(1, "R4 hs hit");
    chk("R4 hs timeout at 64", 32'(rawStatus[6]), 1);
    popB("R5 hs drain");
    chk("R5 hs cleared", 32'(rawStatus[6]), 0);
    setIdle(); highSpeed = 0; cyc("R4 hs off");

    // overrun
    for (int i = 0; i < 17; i++) pushB(8'(i + 1), "R7 fill");
    chk("R7 overrun set", 32'(overrunFlag), 1);
    chk("R7 level full", 32'(fifoLevel), 16);
    setIdle(); rdEn = 1; rxValid = 1; rxData = 8'h77; cyc("R7 push with pop");
    chk("R7 still full", 32'(fifoLevel), 16);
    for (int i = 0; i < 15; i++) popB("R7 drain");
    chk("R7 last kept", 32'(rdData), 32'h77);
    popB("R7 drain last");
    popB("R1 empty read");
    chk("R1 empty read data", 32'(rdData), 0);
    chk("R1 empty read level", 32'(fifoLevel), 0);
    wrReg(2'd1, 11'h400, "R6 clear oe");
    chk("R6 overrun cleared", 32'(overrunFlag), 0);

    // error pass-through
    setIdle(); frameErrIn = 1; cyc("R8 fe");
    setIdle(); parityErrIn = 1; cyc("R8 pe");
    setIdle(); breakErrIn = 1; cyc("R8 be");
    chk("R8 error bits", 32'(rawStatus[9:7]), 32'h7);
    wrReg(2'd0, 11'h000, "R9 unmask");
    chk("R9 irq masked off", 32'(irqOut), 0);
    setIdle(); regWe = 1; regSel = 2'd1; regWdata = 11'h380; frameErrIn = 1; cyc("R6 set wins");
    chk("R6 set wins over clear", 32'(rawStatus[9:7]), 32'h1);
    wrReg(2'd1, 11'h7FF, "R6 clear all");

    // trigger code 7 selects 14
    wrReg(2'd2, 11'd7, "R2 trig14");
    for (int i = 0; i < 14; i++) begin
      pushB(8'(i), "R2 fill");
      if (i == 12) chk("R2 13 below", 32'(rawStatus[4]), 0);
    end
    chk("R2 14 at level", 32'(rawStatus[4]), 1);
    for (int i = 0; i < 14; i++) popB("R2 empty");

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      setIdle();
      rxValid     = ($urandom % 4) == 0;
      rxData      = 8'($urandom);
      rdEn        = ($urandom % 5) == 0;
      baudTick    = ($urandom % 2) == 0;
      frameErrIn  = ($urandom % 97) == 0;
      parityErrIn = ($urandom % 97) == 0;
      breakErrIn  = ($urandom % 97) == 0;
      if (($urandom % 24) == 0) begin
        regWe = 1; regSel = 2'($urandom); regWdata = 11'($urandom);
      end
      if (q.size() == 0 && ($urandom % 40) == 0) highSpeed = ~highSpeed;
      cyc("R3 random model");
    end

    summary();
    $finish;
  end
endmodule